// File: doc/BRIEF.md
# Randomized Stall and Dummy-Activity Countermeasure Controller

This controller runs next to a round-based block cipher core and makes the core's timing and power profile harder to correlate with the data it processes. Each time the core signals the start of a block, the controller draws a pseudo-random word from a seeded generator. From that word it decides how many extra stall cycles to insert and whether spurious switching activity is switched on for that block. The core holds its state while `stall` is high. A separate logic island acts on `dummy_en`.

Four countermeasure types can each be turned on or off on its own. Two of them each add at most one stall cycle. One adds a random count of stall cycles, and its ceiling depends on the key length in use. The fourth controls the dummy-activity request. None of them acts until a seed has been written. Writing a different key size makes them inert again until the next seed is written.

Top module: `cm_jitter_ctrl`

## Requirements
- R1: After reset `seed_valid`, `stall` and `dummy_en` are 0. The enable field is 4'b1111 and the held key size is 2'b00.
- R2: A `seed_we` pulse sets `seed_valid` in the next cycle and loads the generator with `seed_data`. A seed of zero is replaced by 32'h5A5A_C3C3.
- R3: A block start made while `seed_valid` is 0 causes no stall cycles, drives `dummy_en` to 0 and leaves the generator unchanged.
- R4: An accepted start with a valid seed advances the generator one step: next = (s << 1) XOR (s[31] ? 32'h0040_0007 : 0). All decisions for that block use the new value r.
- R5: Enable bit 0 adds one stall cycle when r[0] is 1. Enable bit 1 adds one stall cycle when r[1] is 1.
- R6: Enable bit 2 adds r[15:8] mod (cap+1) stall cycles. cap is 11 for key size 2'b00, 13 for 2'b01, and 15 for 2'b10 or 2'b11.
- R7: `stall` goes high in the cycle after the start edge and stays high for exactly the total of the enabled contributions. A total of 0 gives no stall.
- R8: At an accepted start, `dummy_en` becomes en[3] AND r[2]. It holds that value until the next accepted start, and is forced to 0 whenever `seed_valid` is 0.
- R9: A `ks_we` write whose value differs from the held key size clears `seed_valid`. Rewriting the same value leaves it set. If `seed_we` is also high in that cycle, the seed write wins.
- R10: A `blk_start` raised while `stall` is high is ignored: the stall length and the generator are not affected.
- R11: A write on `en_we` replaces the enable field. A cleared bit removes that type's contribution from every block started afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_we | input | 1 | Write strobe for the enable field |
| en_data | input | 4 | Enable field: bit n turns on type n+1 |
| seed_we | input | 1 | Seed write strobe |
| seed_data | input | 32 | Seed value |
| ks_we | input | 1 | Key size write strobe |
| ks_data | input | 2 | Key size: 00=128, 01=192, 10/11=256 bit |
| blk_start | input | 1 | Block start pulse from the cipher core |
| seed_valid | output | 1 | A seed is present for the current key size |
| stall | output | 1 | Freeze request to the cipher core |
| dummy_en | output | 1 | Spurious switching activity enable |

## Verification
The bench builds the block with its default ceilings of 11, 13 and 15 and an 8-bit random field for the type-3 draw. This makes every total from 0 to 17 stall cycles reachable, and the bench visits all three ceilings through key size writes, including the reserved code. Random seeds, random enable masks and random key size changes are mixed with directed cases: the zero seed, a rewrite of the same key size, a start raised during a stall, and a seed written together with a key change.

// File: rtl/cmj_pkg.sv
package cmj_pkg;

    localparam int          PRNG_W       = 32;
    localparam logic [31:0] PRNG_POLY    = 32'h0040_0007;
    localparam logic [31:0] PRNG_ZERO_SUB = 32'h5A5A_C3C3;

    typedef enum logic [1:0] {
        KS_128 = 2'b00,
        KS_192 = 2'b01,
        KS_256 = 2'b10,
        KS_RSV = 2'b11
    } key_size_e;

    typedef struct packed {
        logic dummy;
        logic multi;
        logic one_b;
        logic one_a;
    } cm_en_t;

    typedef struct packed {
        logic seed_we;
        logic ks_we;
        logic ks_diff;
    } valid_evt_t;

    function automatic logic [PRNG_W-1:0] prng_step(input logic [PRNG_W-1:0] s);
        return {s[PRNG_W-2:0], 1'b0} ^ (s[PRNG_W-1] ? PRNG_POLY : '0);
    endfunction

    function automatic logic [PRNG_W-1:0] seed_fix(input logic [PRNG_W-1:0] s);
        return (s == '0) ? PRNG_ZERO_SUB : s;
    endfunction

endpackage

// File: rtl/cmj_prng.sv
module cmj_prng
    import cmj_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PRNG_W-1:0] load_val,
    input  logic              step,
    output logic [PRNG_W-1:0] nxt
);
    logic [PRNG_W-1:0] state_q;

    assign nxt = prng_step(state_q);

    always_ff @(posedge clk) begin
        if (rst)       state_q <= PRNG_ZERO_SUB;
        else if (load) state_q <= seed_fix(load_val);
        else if (step) state_q <= nxt;
    end
endmodule

// File: rtl/cmj_decide.sv
module cmj_decide
    import cmj_pkg::*;
#(
    parameter int CAP_K128 = 11,
    parameter int CAP_K192 = 13,
    parameter int CAP_K256 = 15,
    parameter int RAW_W    = 8,
    parameter int CNT_W    = 5
) (
    input  logic [PRNG_W-1:0] draw,
    input  cm_en_t            en,
    input  key_size_e         ks,
    output logic [CNT_W-1:0]  total,
    output logic              dummy
);
    localparam int RAW_LSB = 8;

    logic [RAW_W-1:0] raw;
    logic [RAW_W-1:0] modulus;
    logic [RAW_W-1:0] rem;
    logic [CNT_W-1:0] c1, c2, c3;

    assign raw = draw[RAW_LSB +: RAW_W];

    always_comb begin
        unique case (ks)
            KS_128:  modulus = RAW_W'(CAP_K128 + 1);
            KS_192:  modulus = RAW_W'(CAP_K192 + 1);
            default: modulus = RAW_W'(CAP_K256 + 1);
        endcase
    end

    assign rem   = raw % modulus;
    assign c1    = (en.one_a && draw[0]) ? CNT_W'(1) : '0;
    assign c2    = (en.one_b && draw[1]) ? CNT_W'(1) : '0;
    assign c3    = en.multi ? CNT_W'(rem) : '0;
    assign total = c1 + c2 + c3;
    assign dummy = en.dummy && draw[2];
endmodule

// File: rtl/cmj_stall_timer.sv
module cmj_stall_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             stall
);
    logic [CNT_W-1:0] cnt_q;

    assign stall = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (load)  cnt_q <= load_val;
        else if (stall) cnt_q <= cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/cm_jitter_ctrl.sv
module cm_jitter_ctrl
    import cmj_pkg::*;
#(
    parameter int CAP_K128 = 11,
    parameter int CAP_K192 = 13,
    parameter int CAP_K256 = 15,
    parameter int RAW_W    = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en_we,
    input  logic [3:0]  en_data,
    input  logic        seed_we,
    input  logic [31:0] seed_data,
    input  logic        ks_we,
    input  logic [1:0]  ks_data,
    input  logic        blk_start,
    output logic        seed_valid,
    output logic        stall,
    output logic        dummy_en
);
    localparam int CAP_A     = (CAP_K128 > CAP_K192) ? CAP_K128 : CAP_K192;
    localparam int CAP_MAX   = (CAP_A > CAP_K256) ? CAP_A : CAP_K256;
    localparam int TOTAL_MAX = CAP_MAX + 2;
    localparam int CNT_W     = $clog2(TOTAL_MAX + 1);

    cm_en_t            en_q;
    key_size_e         ks_q;
    logic              valid_q;
    logic              dummy_q;
    logic              accept;
    logic              live;
    logic [PRNG_W-1:0] draw;
    logic [CNT_W-1:0]  total;
    logic              dec_dummy;
    valid_evt_t        vev;

    assign accept = blk_start && !stall;
    assign live   = accept && valid_q;

    assign vev.seed_we = seed_we;
    assign vev.ks_we   = ks_we;
    assign vev.ks_diff = (key_size_e'(ks_data) != ks_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '1;
            ks_q    <= KS_128;
            valid_q <= 1'b0;
            dummy_q <= 1'b0;
        end else begin
            if (en_we) en_q <= cm_en_t'(en_data);
            if (ks_we) ks_q <= key_size_e'(ks_data);
            if (vev.seed_we)                   valid_q <= 1'b1;
            else if (vev.ks_we && vev.ks_diff) valid_q <= 1'b0;
            if (accept) dummy_q <= live && dec_dummy;
        end
    end

    cmj_prng u_prng (
        .clk      (clk),
        .rst      (rst),
        .load     (seed_we),
        .load_val (seed_data),
        .step     (live),
        .nxt      (draw)
    );

    cmj_decide #(
        .CAP_K128 (CAP_K128),
        .CAP_K192 (CAP_K192),
        .CAP_K256 (CAP_K256),
        .RAW_W    (RAW_W),
        .CNT_W    (CNT_W)
    ) u_decide (
        .draw  (draw),
        .en    (en_q),
        .ks    (ks_q),
        .total (total),
        .dummy (dec_dummy)
    );

    cmj_stall_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (live),
        .load_val (total),
        .stall    (stall)
    );

    assign seed_valid = valid_q;
    assign dummy_en   = dummy_q && valid_q;
endmodule

// File: rtl/cmj_checker.sv
module cmj_checker #(
    parameter int RUN_MAX = 17
) (
    input logic       clk,
    input logic       rst,
    input logic       blk_start,
    input logic       seed_we,
    input logic       ks_we,
    input logic [1:0] ks_data,
    input logic [1:0] ks_q,
    input logic       seed_valid,
    input logic       stall,
    input logic       dummy_en
);
    int run_len;

    always_ff @(posedge clk) begin
        if (rst)        run_len <= 0;
        else if (stall) run_len <= run_len + 1;
        else            run_len <= 0;
    end

    assert_seed_sets_R2: assert property (@(posedge clk) disable iff (rst)
        seed_we |=> seed_valid);

    assert_inert_start_R3: assert property (@(posedge clk) disable iff (rst)
        (blk_start && !stall && !seed_valid) |=> !stall);

    assert_stall_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        run_len <= RUN_MAX);

    assert_stall_after_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(stall) |-> $past(blk_start));

    assert_dummy_gated_R8: assert property (@(posedge clk) disable iff (rst)
        !seed_valid |-> !dummy_en);

    assert_keychange_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (ks_we && !seed_we && ks_data != ks_q) |=> !seed_valid);
endmodule

bind cm_jitter_ctrl cmj_checker #(.RUN_MAX(TOTAL_MAX)) u_cmj_checker (
    .clk        (clk),
    .rst        (rst),
    .blk_start  (blk_start),
    .seed_we    (seed_we),
    .ks_we      (ks_we),
    .ks_data    (ks_data),
    .ks_q       (ks_q),
    .seed_valid (seed_valid),
    .stall      (stall),
    .dummy_en   (dummy_en)
);

// File: tb/tb_cm_jitter_ctrl.sv
`timescale 1ns/1ps
module tb_cm_jitter_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_we = 0, seed_we = 0, ks_we = 0, blk_start = 0;
    logic [3:0]  en_data = '0;
    logic [31:0] seed_data = '0;
    logic [1:0]  ks_data = '0;
    logic        seed_valid, stall, dummy_en;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_lfsr;
    logic        m_valid;
    logic [1:0]  m_ks;
    logic [3:0]  m_en;

    always #4 clk = ~clk;

    cm_jitter_ctrl dut (
        .clk(clk), .rst(rst), .en_we(en_we), .en_data(en_data),
        .seed_we(seed_we), .seed_data(seed_data), .ks_we(ks_we), .ks_data(ks_data),
        .blk_start(blk_start), .seed_valid(seed_valid), .stall(stall), .dummy_en(dummy_en)
    );

    function automatic logic [31:0] f_step(input logic [31:0] s);
        logic [31:0] t = s << 1;
        if (s[31]) t = t ^ 32'h0040_0007;
        return t;
    endfunction

    function automatic int f_total(input logic [31:0] r, input logic [3:0] en, input logic [1:0] ks);
        int cap = (ks == 2'd0) ? 11 : (ks == 2'd1) ? 13 : 15;
        int t = 0;
        if (en[0] && r[0]) t++;
        if (en[1] && r[1]) t++;
        if (en[2]) t += int'(r[15:8]) % (cap + 1);
        return t;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_en(input logic [3:0] v);
        @(negedge clk); en_we = 1; en_data = v;
        @(negedge clk); en_we = 0;
        m_en = v;
    endtask

    task automatic wr_seed(input logic [31:0] v);
        @(negedge clk); seed_we = 1; seed_data = v;
        @(negedge clk); seed_we = 0;
        m_lfsr = (v == 0) ? 32'h5A5A_C3C3 : v;
        m_valid = 1;
        chk(seed_valid == 1, "R2", "seed_valid after seed write", seed_valid, 1);
    endtask

    task automatic wr_ks(input logic [1:0] v);
        @(negedge clk); ks_we = 1; ks_data = v;
        @(negedge clk); ks_we = 0;
        if (v != m_ks) m_valid = 0;
        m_ks = v;
        chk(seed_valid == m_valid, "R9", "seed_valid after key size write", seed_valid, m_valid);
    endtask

    task automatic run_block(input bit inject, input string req);
        int exp_t = 0;
        bit exp_d = 0;
        int n = 0;
        if (m_valid) begin
            m_lfsr = f_step(m_lfsr);
            exp_t  = f_total(m_lfsr, m_en, m_ks);
            exp_d  = m_en[3] && m_lfsr[2];
        end
        @(negedge clk); blk_start = 1;
        @(negedge clk); blk_start = 0;
        chk(dummy_en == exp_d, "R8", "dummy_en after start", dummy_en, exp_d);
        while (stall && n < 40) begin
            if (inject && n == 1) blk_start = 1;
            n++;
            @(negedge clk);
            blk_start = 0;
        end
        chk(n == exp_t, req, "stall cycle count", n, exp_t);
        if (!m_valid) chk(dummy_en == 0, "R3", "dummy_en while inert", dummy_en, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        m_lfsr = 32'h5A5A_C3C3; m_valid = 0; m_ks = 0; m_en = 4'hF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(seed_valid == 0, "R1", "seed_valid at reset", seed_valid, 0);
        chk(stall == 0, "R1", "stall at reset", stall, 0);
        chk(dummy_en == 0, "R1", "dummy_en at reset", dummy_en, 0);

        // R3: inert before any seed; generator must not step
        run_block(0, "R3");
        run_block(0, "R3");

        // R1/R4/R7: default enables all on, nonzero seed
        wr_seed(32'h1357_9BDF);
        for (int i = 0; i < 6; i++) run_block(0, "R7");

        // R2: zero seed substitution
        wr_seed(32'h0);
        for (int i = 0; i < 4; i++) run_block(0, "R2");

        // R6: each key size ceiling, only multi-cycle type on
        wr_en(4'b0100);
        for (int k = 0; k < 4; k++) begin
            wr_ks(2'(k));
            if (!m_valid) wr_seed(32'hC0DE_0000 + 32'(k));
            for (int i = 0; i < 6; i++) run_block(0, "R6");
        end

        // R5: single-cycle types only
        wr_en(4'b0011);
        for (int i = 0; i < 6; i++) run_block(0, "R5");

        // R11: all off -> no stall, no dummy
        wr_en(4'b0000);
        for (int i = 0; i < 3; i++) run_block(0, "R11");

        // R9: same key size rewrite keeps seed valid; seed+change same cycle
        wr_en(4'hF);
        wr_ks(m_ks);
        run_block(0, "R9");
        @(negedge clk); ks_we = 1; ks_data = ~m_ks; seed_we = 1; seed_data = 32'hFACE_B00C;
        @(negedge clk); ks_we = 0; seed_we = 0;
        m_ks = ~m_ks; m_lfsr = 32'hFACE_B00C; m_valid = 1;
        chk(seed_valid == 1, "R9", "seed write wins over key change", seed_valid, 1);
        run_block(0, "R9");

        // R10: start during stall ignored
        for (int i = 0; i < 6; i++) run_block(1, "R10");
        run_block(0, "R10");

        // R4: random mix
        for (int i = 0; i < 60; i++) begin
            if ($urandom_range(0, 5) == 0) wr_ks(2'($urandom_range(0, 3)));
            if (!m_valid && $urandom_range(0, 3) != 0) wr_seed($urandom);
            if ($urandom_range(0, 3) == 0) wr_en(4'($urandom_range(0, 15)));
            run_block($urandom_range(0, 4) == 0, "R4");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule